// File: doc/BRIEF.md
# Debug Trace Buffer Controller

This block records processor bus activity into a small circular trace memory while a debug session is armed. Each clock it looks at the current bus cycle (address, data, program counter and three cycle-kind flags) and, depending on the selected storage mode, writes zero, one or two 40-bit entries. A separate four-state sequencer supplies a trigger pulse when it reaches its final state. The block uses that pulse to decide when capture begins or ends, according to the selected alignment policy.

Storage is blocked while the device is secure, and while background debug is both enabled and active. An armed session survives a background-debug episode and resumes capture when that episode ends. When capture stops, the block raises a done flag and reports the number of valid entries. A sticky overflow flag shows that older entries were overwritten. Dropping the arm input clears all session state. A plain index port reads out any physical slot of the memory.

Top module: `trace_capture_ctrl`

## Requirements
- R1: When reset is applied or arm is low, count, done and overflow read 0 and the write index returns to slot 0.
- R2: mode=0 (flow): a cycle with cof high writes two entries to consecutive slots. The first is source tag 0 carrying pc. The second is destination tag 1 carrying bus_addr. Cycles without cof store nothing. Entry layout: bits [39:38] tag, [37:16] address field, [15:0] data field (zero for tags 0, 1 and 3).
- R3: mode=1 (loop): the same as mode 0, except that a flow event is not stored when its pc equals the source of the last stored flow event.
- R4: mode=2 (detail): every cycle with both opfetch and freecyc low stores one entry with tag 2, bus_addr in the address field and bus_data in the data field.
- R5: mode=3 (program counter): every cycle stores one entry with tag 3 carrying pc.
- R6: align=0 (begin): nothing is stored before the trigger cycle. Storing starts with the trigger cycle and stops with done set once DEPTH entries are held. Nothing is overwritten.
- R7: align=1 (mid): storing runs before the trigger. Counting from the trigger cycle, once DEPTH/2 further entries have been written, capture stops with done set.
- R8: align=2 (end): storing runs continuously. The trigger cycle's own entry is stored, and done is set at that edge.
- R9: Writes wrap around the memory. count saturates at DEPTH. overflow becomes 1 on the first write that replaces an older entry, and stays 1 until disarm.
- R10: While secure is high nothing is stored. A trigger is still honoured.
- R11: While bdm_en and bdm_act are both high nothing is stored, the session stays armed, and storing resumes when bdm_act falls. bdm_act has no effect while bdm_en is low.
- R12: Once done is set, count and the memory contents stay frozen until arm is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Session armed (level); low clears the session |
| mode | input | 2 | Storage mode: 0 flow, 1 loop, 2 detail, 3 program counter |
| align | input | 2 | Trigger alignment: 0 begin, 1 mid, 2 or 3 end |
| secure | input | 1 | Secure device; blocks storing |
| bdm_en | input | 1 | Background debug enabled |
| bdm_act | input | 1 | Background debug active |
| trig | input | 1 | Final-state pulse from the sequencer |
| bus_addr | input | ADDR_W | Bus address of this cycle |
| bus_data | input | DATA_W | Bus data of this cycle |
| pc | input | ADDR_W | Program counter of this cycle |
| cof | input | 1 | Change of flow in this cycle |
| opfetch | input | 1 | This cycle is an opcode fetch |
| freecyc | input | 1 | This cycle is a free cycle |
| rd_idx | input | $clog2(DEPTH) | Physical slot to read |
| rd_entry | output | 2+ADDR_W+DATA_W | Contents of slot rd_idx |
| done | output | 1 | Capture has stopped |
| count | output | $clog2(DEPTH)+1 | Number of valid entries |
| overflow | output | 1 | Older entries were overwritten |

## Verification
The bench builds the block with DEPTH=8, leaving the field widths at their defaults. With only eight slots, a handful of cycles fills the memory, wraps the write index, and reaches the full-buffer stop of begin alignment. Mid alignment then halts after four post-trigger entries. With these small values, the slot that must survive a mid-alignment stop and the exact slot of the last stored entry can be checked directly.

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          arm,
  input  logic [1:0]                    mode,
  input  logic [1:0]                    align,
  input  logic                          secure,
  input  logic                          bdm_en,
  input  logic                          bdm_act,
  input  logic                          trig,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_data,
  input  logic [ADDR_W-1:0]             pc,
  input  logic                          cof,
  input  logic                          opfetch,
  input  logic                          freecyc,
  input  logic [$clog2(DEPTH)-1:0]      rd_idx,
  output logic [2+ADDR_W+DATA_W-1:0]    rd_entry,
  output logic                          done,
  output logic [$clog2(DEPTH):0]        count,
  output logic                          overflow
);
  localparam int IW   = $clog2(DEPTH);
  localparam int CW   = IW + 1;
  localparam int EW   = 2 + ADDR_W + DATA_W;
  localparam int HALF = DEPTH / 2;

  localparam logic [1:0] M_FLOW = 2'd0, M_LOOP = 2'd1, M_DETAIL = 2'd2, M_PC = 2'd3;
  localparam logic [1:0] A_BEGIN = 2'd0, A_MID = 2'd1;
  localparam logic [1:0] T_SRC = 2'd0, T_DST = 2'd1, T_DATA = 2'd2, T_PC = 2'd3;

  logic [EW-1:0]     mem [DEPTH];
  logic [IW-1:0]     wp;
  logic [CW-1:0]     post;
  logic              trig_seen;
  logic [ADDR_W-1:0] last_src;
  logic              last_src_vld;

  logic              flow_mode, dup, gate_ok, trig_now, phase_ok, sess;
  logic [1:0]        req_n, n;
  logic [CW:0]       room, cnt_sum, post_sum;
  logic [EW-1:0]     e0, e1;
  logic              stop_now;

  assign flow_mode = (mode == M_FLOW) || (mode == M_LOOP);
  assign dup       = (mode == M_LOOP) && last_src_vld && (pc == last_src);
  assign sess      = arm && !done;
  assign gate_ok   = sess && !secure && !(bdm_en && bdm_act);
  assign trig_now  = trig || trig_seen;
  assign phase_ok  = (align != A_BEGIN) || trig_now;

  always_comb begin
    req_n = 2'd0;
    e0    = '0;
    e1    = {T_DST, bus_addr, {DATA_W{1'b0}}};
    case (mode)
      M_FLOW, M_LOOP: begin
        req_n = (cof && !dup) ? 2'd2 : 2'd0;
        e0    = {T_SRC, pc, {DATA_W{1'b0}}};
      end
      M_DETAIL: begin
        req_n = (!opfetch && !freecyc) ? 2'd1 : 2'd0;
        e0    = {T_DATA, bus_addr, bus_data};
      end
      default: begin
        req_n = 2'd1;
        e0    = {T_PC, pc, {DATA_W{1'b0}}};
      end
    endcase
  end

  always_comb begin
    if (align == A_BEGIN)
      room = (CW+1)'(DEPTH) - {1'b0, count};
    else if (align == A_MID && trig_now)
      room = (CW+1)'(HALF) - {1'b0, post};
    else
      room = (CW+1)'(2);
  end

  assign n        = (gate_ok && phase_ok) ? (({{(CW-1){1'b0}}, req_n} > room) ? room[1:0] : req_n) : 2'd0;
  assign cnt_sum  = {1'b0, count} + (CW+1)'(n);
  assign post_sum = {1'b0, post} + (CW+1)'(n);

  always_comb begin
    stop_now = 1'b0;
    if (sess) begin
      if (align == A_BEGIN)
        stop_now = trig_now && (cnt_sum >= (CW+1)'(DEPTH));
      else if (align == A_MID)
        stop_now = trig_now && (post_sum >= (CW+1)'(HALF));
      else
        stop_now = trig;
    end
  end

  always_ff @(posedge clk) begin
    if (n != 2'd0) mem[wp] <= e0;
    if (n == 2'd2) mem[wp + IW'(1)] <= e1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp           <= '0;
      count        <= '0;
      post         <= '0;
      done         <= 1'b0;
      overflow     <= 1'b0;
      trig_seen    <= 1'b0;
      last_src     <= '0;
      last_src_vld <= 1'b0;
    end else if (!arm) begin
      wp           <= '0;
      count        <= '0;
      post         <= '0;
      done         <= 1'b0;
      overflow     <= 1'b0;
      trig_seen    <= 1'b0;
      last_src_vld <= 1'b0;
    end else begin
      wp    <= wp + IW'(n);
      count <= (cnt_sum > (CW+1)'(DEPTH)) ? CW'(DEPTH) : cnt_sum[CW-1:0];
      if (cnt_sum > (CW+1)'(DEPTH)) overflow <= 1'b1;
      if (sess && trig) trig_seen <= 1'b1;
      if (trig_now && align == A_MID) post <= post_sum[CW-1:0];
      if (flow_mode && n != 2'd0) begin
        last_src     <= pc;
        last_src_vld <= 1'b1;
      end
      if (stop_now) done <= 1'b1;
    end
  end

  assign rd_entry = mem[rd_idx];
endmodule

// File: rtl/trace_capture_sva.sv
module trace_capture_sva #(
  parameter int DEPTH = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   arm,
  input logic                   secure,
  input logic                   bdm_en,
  input logic                   bdm_act,
  input logic                   done,
  input logic [$clog2(DEPTH):0] count,
  input logic                   overflow
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count <= ($clog2(DEPTH)+1)'(DEPTH)); // R9
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n) overflow |-> count == ($clog2(DEPTH)+1)'(DEPTH)); // R9
  AST_DISARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !arm |=> (count == '0 && !done && !overflow)); // R1
  AST_SECURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (arm && secure) |=> (!arm || $stable(count))); // R10
  AST_BDM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (arm && bdm_en && bdm_act) |=> (!arm || $stable(count))); // R11
  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (arm && done) |=> (!arm || ($stable(count) && done))); // R12
endmodule

bind trace_capture_ctrl trace_capture_sva #(.DEPTH(DEPTH)) i_trace_capture_sva (
  .clk(clk), .rst_n(rst_n), .arm(arm), .secure(secure), .bdm_en(bdm_en),
  .bdm_act(bdm_act), .done(done), .count(count), .overflow(overflow)
);

// File: tb/test_trace_capture_ctrl.sv
`timescale 1ns/1ps
module test_trace_capture_ctrl;
  localparam int DEPTH = 8;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int IW = $clog2(DEPTH);
  localparam int EW = 2 + AW + DW;

  logic clk = 0, rst_n = 0, arm = 0, secure = 0, bdm_en = 0, bdm_act = 0, trig = 0;
  logic [1:0] mode = 0, align = 2;
  logic [AW-1:0] bus_addr = 0, pc = 0;
  logic [DW-1:0] bus_data = 0;
  logic cof = 0, opfetch = 0, freecyc = 0;
  logic [IW-1:0] rd_idx = 0;
  logic [EW-1:0] rd_entry;
  logic done, overflow;
  logic [IW:0] count;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  trace_capture_ctrl #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) i_trace_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .align(align), .secure(secure),
    .bdm_en(bdm_en), .bdm_act(bdm_act), .trig(trig), .bus_addr(bus_addr), .bus_data(bus_data),
    .pc(pc), .cof(cof), .opfetch(opfetch), .freecyc(freecyc), .rd_idx(rd_idx),
    .rd_entry(rd_entry), .done(done), .count(count), .overflow(overflow));

  // {opfetch, freecyc, expected count after the cycle}
  localparam logic [5:0] VEC [6] = '{
    {1'b0, 1'b0, 4'd1}, {1'b1, 1'b0, 4'd1}, {1'b0, 1'b1, 4'd1},
    {1'b0, 1'b0, 4'd2}, {1'b1, 1'b1, 4'd2}, {1'b0, 1'b0, 4'd3}};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rearm(input logic [1:0] m, input logic [1:0] a);
    arm = 0; cof = 0; trig = 0; step();
    mode = m; align = a; arm = 1;
  endtask

  function automatic logic [EW-1:0] ent(input logic [1:0] t, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    return {t, ad, d};
  endfunction

  task automatic peek(input int idx, input logic [EW-1:0] exp, input string req);
    rd_idx = IW'(idx); #0.1;
    chk(rd_entry == exp, req, rd_entry, exp);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    chk(count == 0 && !done && !overflow, "R1 reset", {count, done, overflow}, 0);
    rst_n = 1; step();

    // R4 detail-mode vector table
    rearm(2'd2, 2'd2);
    for (int i = 0; i < 6; i++) begin
      opfetch = VEC[i][5]; freecyc = VEC[i][4];
      bus_addr = AW'(32'h1000 + i); bus_data = DW'(16'hA0 + i);
      step();
      chk(count == VEC[i][3:0], "R4 count", count, VEC[i][3:0]);
    end
    opfetch = 0; freecyc = 0;
    peek(0, ent(2'd2, 22'h1000, 16'hA0), "R4 entry0");
    peek(1, ent(2'd2, 22'h1003, 16'hA3), "R4 entry1");

    // R2 flow mode
    rearm(2'd0, 2'd2);
    pc = 22'h100; bus_addr = 22'h200; cof = 1; step();
    cof = 0; step();
    chk(count == 2, "R2 count", count, 2);
    peek(0, ent(2'd0, 22'h100, 0), "R2 source");
    peek(1, ent(2'd1, 22'h200, 0), "R2 destination");

    // R3 loop mode
    rearm(2'd1, 2'd2);
    cof = 1; pc = 22'h300; bus_addr = 22'h10; step();
    pc = 22'h300; step();
    chk(count == 2, "R3 duplicate dropped", count, 2);
    pc = 22'h304; step();
    chk(count == 4, "R3 new source", count, 4);
    pc = 22'h300; step();
    chk(count == 6, "R3 non-adjacent repeat", count, 6);
    cof = 0;

    // R5 program counter mode, R9 wrap
    rearm(2'd3, 2'd2);
    for (int i = 0; i < 5; i++) begin pc = AW'(32'h20 + i); step(); end
    chk(count == 5, "R5 count", count, 5);
    peek(3, ent(2'd3, 22'h23, 0), "R5 entry");
    for (int i = 5; i < 10; i++) begin pc = AW'(32'h20 + i); step(); end
    chk(count == 8 && overflow, "R9 saturate and overflow", {count, overflow}, {4'd8, 1'b1});
    peek(1, ent(2'd3, 22'h29, 0), "R9 wrapped slot");

    // R8 end alignment
    rearm(2'd3, 2'd2);
    for (int i = 0; i < 3; i++) begin pc = AW'(32'h30 + i); step(); end
    trig = 1; pc = 22'h33; step(); trig = 0;
    chk(count == 4 && done, "R8 stop at trigger", {count, done}, {4'd4, 1'b1});
    peek(3, ent(2'd3, 22'h33, 0), "R8 trigger entry");
    pc = 22'h34; step(); step();
    chk(count == 4, "R12 frozen after done", count, 4);
    peek(4, ent(2'd3, 22'h24, 0), "R12 slot untouched");

    // R6 begin alignment
    rearm(2'd3, 2'd0);
    for (int i = 0; i < 3; i++) begin pc = AW'(32'h50 + i); step(); end
    chk(count == 0, "R6 nothing before trigger", count, 0);
    trig = 1; pc = 22'h60; step(); trig = 0;
    for (int i = 1; i < 8; i++) begin pc = AW'(32'h60 + i); step(); end
    chk(count == 8 && done && !overflow, "R6 full stop", {count, done, overflow}, {4'd8, 1'b1, 1'b0});
    pc = 22'h70; step(); step();
    peek(0, ent(2'd3, 22'h60, 0), "R6 first entry kept");
    peek(7, ent(2'd3, 22'h67, 0), "R6 last entry");

    // R7 mid alignment
    rearm(2'd3, 2'd1);
    for (int i = 0; i < 10; i++) begin pc = AW'(32'h10 + i); step(); end
    trig = 1; pc = 22'h40; step(); trig = 0;
    for (int i = 1; i < 3; i++) begin pc = AW'(32'h40 + i); step(); end
    chk(!done, "R7 not yet done", done, 0);
    pc = 22'h43; step();
    chk(done && count == 8, "R7 done after half", {done, count}, {1'b1, 4'd8});
    pc = 22'h44; step();
    peek(5, ent(2'd3, 22'h43, 0), "R7 last post entry");
    peek(6, ent(2'd3, 22'h16, 0), "R7 pre-trigger survives");

    // R10 secure
    rearm(2'd3, 2'd2);
    secure = 1; step(); step(); step();
    chk(count == 0, "R10 secure blocks", count, 0);
    secure = 0; step();
    chk(count == 1, "R10 resumes", count, 1);
    secure = 1; trig = 1; step(); trig = 0;
    chk(done && count == 1, "R10 trigger honoured", {done, count}, {1'b1, 4'd1});
    secure = 0;

    // R11 background debug
    rearm(2'd3, 2'd2);
    bdm_en = 1; bdm_act = 1; step(); step();
    chk(count == 0 && !done, "R11 blocked, still armed", {count, done}, 0);
    bdm_act = 0; step();
    chk(count == 1, "R11 resumes", count, 1);
    bdm_en = 0; bdm_act = 1; step();
    chk(count == 2, "R11 inactive when disabled", count, 2);
    bdm_act = 0;

    // R1 disarm
    arm = 0; step();
    chk(count == 0 && !done && !overflow, "R1 disarm clears", {count, done, overflow}, 0);
    arm = 1; mode = 2'd3; align = 2'd2; pc = 22'h77; step();
    peek(0, ent(2'd3, 22'h77, 0), "R1 index back to 0");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule